// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses for one read or write burst of a double-data-rate memory device. A single-cycle `start` pulse presents a starting column, a burst length code and an ordering bit. From the next cycle on, the block emits one column address per clock, one for each beat. It flags the final beat with `last`.

The low column bits step through an aligned block whose size equals the burst length. They step either in wrapping ascending order or in XOR-interleaved order. The column bits above that block hold the starting value for the whole burst, so a wrap never carries upward.

While a burst is running, the block reports `busy` and ignores any further `start`. A start that carries the reserved length code produces no beats. Instead, it raises `err` for one cycle. Command decoding, data capture and read latency belong to the surrounding controller.

Top module: `burst_col_seq`

## Requirements
- R1: When `rst` is high at a clock edge, `col_valid`, `last`, `busy` and `err` are low after that edge.
- R2: If `start` is high at an edge while `busy` is low and the length code is valid, the first beat appears after that edge with `col_out` equal to `start_col`.
- R3: Length code 2'b01 gives 2 beats, 2'b10 gives 4 beats and 2'b11 gives 8 beats. `col_valid` is high on consecutive cycles for exactly that many beats.
- R4: `last` is high on the final beat of a burst and low on every other cycle.
- R5: With `order_ilv` = 0, beat k carries the low offset (s + k) mod L. Here s is the start offset (the low log2(L) bits of `start_col`) and L is the burst length.
- R6: With `order_ilv` = 1, beat k carries the low offset s XOR k.
- R7: On every beat, the bits of `col_out` above the low log2(L) bits equal those of `start_col`, including when a sequential burst passes the block boundary.
- R8: A start with length code 2'b00 while `busy` is low produces no beats and leaves `busy` low. `err` is high for the one cycle after that start.
- R9: A `start` while `busy` is high is ignored. Values on `start_col`, `len_code` and `order_ilv` have no effect except at an accepted start.
- R10: `busy` is high exactly while beats are being emitted. It is low on the cycle after the last beat, and a `start` in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a burst |
| start_col | input | COL_W | Starting column address |
| len_code | input | 2 | Burst length code (01=2, 10=4, 11=8, 00 reserved) |
| order_ilv | input | 1 | Burst order: 0 sequential, 1 interleaved |
| col_out | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | `col_out` carries a beat |
| last | output | 1 | Current beat is the final one |
| busy | output | 1 | A burst is in progress, so starts are ignored |
| err | output | 1 | Previous start used the reserved length code |

## Verification
The bench builds the block with the default `COL_W` of 10. This leaves seven column bits above the widest block, so nonzero upper bits can be checked for carry leakage. It sweeps every start offset under both orderings and all three lengths, including the all-ones column where a sequential wrap would otherwise carry. It then adds seeded random bursts that drive garbage mode inputs with `start` held high during each burst, and issues back-to-back starts in the cycle `busy` falls.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int OFS_W = 3;

  typedef enum logic [1:0] {
    LEN_RSVD = 2'b00,
    LEN_2    = 2'b01,
    LEN_4    = 2'b10,
    LEN_8    = 2'b11
  } len_code_e;

  typedef struct packed {
    logic             ilv;
    logic [OFS_W-1:0] mask;
    logic [OFS_W-1:0] start_ofs;
  } burst_mode_t;

  function automatic logic [OFS_W-1:0] code_to_mask(input logic [1:0] code);
    case (len_code_e'(code))
      LEN_2:   return OFS_W'(1);
      LEN_4:   return OFS_W'(3);
      LEN_8:   return OFS_W'(7);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/burst_accept.sv
module burst_accept
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             busy,
  input  logic [COL_W-1:0] start_col,
  input  logic [1:0]       len_code,
  input  logic             order_ilv,
  output logic             accept,
  output logic             reject,
  output burst_mode_t      mode,
  output logic [COL_W-1:0] base_col
);
  logic [OFS_W-1:0] new_mask;

  always_comb begin
    new_mask = code_to_mask(len_code);
    accept   = start && !busy && (new_mask != '0);
    reject   = start && !busy && (new_mask == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= '0;
      base_col <= '0;
    end else if (accept) begin
      mode.ilv       <= order_ilv;
      mode.mask      <= new_mask;
      mode.start_ofs <= start_col[OFS_W-1:0];
      base_col       <= start_col;
    end
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [OFS_W-1:0] mask,
  output logic             active,
  output logic [OFS_W-1:0] beat,
  output logic             final_beat
);
  assign final_beat = active && (beat == mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      beat   <= '0;
    end else if (accept) begin
      active <= 1'b1;
      beat   <= OFS_W'(1);
    end else if (active) begin
      beat <= beat + OFS_W'(1);
      if (beat == mask) active <= 1'b0;
    end
  end
endmodule

// File: rtl/burst_ofs_gen.sv
module burst_ofs_gen
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  burst_mode_t      mode,
  input  logic [OFS_W-1:0] beat,
  input  logic [COL_W-1:0] base_col,
  output logic [COL_W-1:0] next_col
);
  localparam int UP_W = COL_W - OFS_W;

  logic [OFS_W-1:0] seq_ofs;
  logic [OFS_W-1:0] ilv_ofs;
  logic [OFS_W-1:0] ofs;
  logic [COL_W-1:0] keep_mask;

  always_comb begin
    seq_ofs   = (mode.start_ofs + beat) & mode.mask;
    ilv_ofs   = (mode.start_ofs ^ beat) & mode.mask;
    ofs       = mode.ilv ? ilv_ofs : seq_ofs;
    keep_mask = ~{{UP_W{1'b0}}, mode.mask};
    next_col  = (base_col & keep_mask) | {{UP_W{1'b0}}, ofs};
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [1:0]       len_code,
  input  logic             order_ilv,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             last,
  output logic             busy,
  output logic             err
);
  logic             accept;
  logic             reject;
  burst_mode_t      mode;
  logic [COL_W-1:0] base_col;
  logic             active;
  logic [OFS_W-1:0] beat;
  logic             final_beat;
  logic [COL_W-1:0] next_col;
  logic [COL_W-1:0] col_q;
  logic             vld_q;
  logic             last_q;
  logic             err_q;

  burst_accept #(.COL_W(COL_W)) u_accept (
    .clk(clk), .rst(rst), .start(start), .busy(vld_q),
    .start_col(start_col), .len_code(len_code), .order_ilv(order_ilv),
    .accept(accept), .reject(reject), .mode(mode), .base_col(base_col)
  );

  burst_beat_ctr u_ctr (
    .clk(clk), .rst(rst), .accept(accept), .mask(mode.mask),
    .active(active), .beat(beat), .final_beat(final_beat)
  );

  burst_ofs_gen #(.COL_W(COL_W)) u_ofs (
    .mode(mode), .beat(beat), .base_col(base_col), .next_col(next_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q  <= '0;
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= reject;
      if (accept) begin
        col_q  <= start_col;
        vld_q  <= 1'b1;
        last_q <= 1'b0;
      end else if (active) begin
        col_q  <= next_col;
        vld_q  <= 1'b1;
        last_q <= final_beat;
      end else begin
        vld_q  <= 1'b0;
        last_q <= 1'b0;
      end
    end
  end

  assign col_out   = col_q;
  assign col_valid = vld_q;
  assign last      = last_q;
  assign busy      = vld_q;
  assign err       = err_q;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic [COL_W-1:0] start_col,
  input logic [COL_W-1:0] col_out,
  input logic             col_valid,
  input logic             last,
  input logic             busy,
  input logic             err
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (!col_valid && !last && !busy && !err));

  assert_first_beat_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(col_valid) |-> (col_out == $past(start_col)));

  assert_last_in_beat_R4: assert property (@(posedge clk) disable iff (rst)
    last |-> col_valid);

  assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (rst)
    (col_valid && $past(col_valid)) |->
      (col_out[COL_W-1:OFS_W] == $past(col_out[COL_W-1:OFS_W])));

  assert_reject_silent_R8: assert property (@(posedge clk) disable iff (rst)
    err |-> (!col_valid && !busy));

  assert_end_after_last_R10: assert property (@(posedge clk) disable iff (rst)
    (col_valid && last) |=> !busy);
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst(rst), .start_col(start_col), .col_out(col_out),
  .col_valid(col_valid), .last(last), .busy(busy), .err(err)
);

// File: tb/burst_col_seq_tb_top.sv
`timescale 1ns/1ps
module burst_col_seq_tb_top;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [1:0]       len_code = 2'b00;
  logic             order_ilv = 1'b0;
  logic [COL_W-1:0] col_out;
  logic             col_valid, last, busy, err;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .start_col(start_col),
    .len_code(len_code), .order_ilv(order_ilv), .col_out(col_out),
    .col_valid(col_valid), .last(last), .busy(busy), .err(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int blen(input logic [1:0] code);
    return (code == 2'b01) ? 2 : (code == 2'b10) ? 4 : 8;
  endfunction

  function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s,
      input logic [1:0] code, input logic ilv, input int k);
    logic [COL_W-1:0] m;
    logic [COL_W-1:0] o;
    m = COL_W'(blen(code) - 1);
    o = ilv ? ((s ^ COL_W'(k)) & m) : ((s + COL_W'(k)) & m);
    return (s & ~m) | o;
  endfunction

  // Called just after a negedge; returns just after the negedge where busy is low.
  task automatic run_burst(input logic [COL_W-1:0] s, input logic [1:0] code,
      input logic ilv, input bit noise);
    int n;
    n = blen(code);
    start = 1'b1; start_col = s; len_code = code; order_ilv = ilv;
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      if (k == 0) chk("R2 first beat", 32'(col_out), 32'(s));
      chk(ilv ? "R6 R7 interleaved col" : "R5 R7 sequential col",
          32'(col_out), 32'(exp_col(s, code, ilv, k)));
      chk("R3 col_valid", 32'(col_valid), 32'd1);
      chk("R4 last", 32'(last), 32'(k == n - 1));
      chk("R10 busy high", 32'(busy), 32'd1);
      if (noise && k < n - 1) begin
        start = 1'b1;
        start_col = COL_W'($urandom);
        len_code = 2'($urandom);
        order_ilv = 1'($urandom);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk("R3 R9 no extra beat", 32'(col_valid), 32'd0);
    chk("R10 busy low", 32'(busy), 32'd0);
    chk("R4 last low", 32'(last), 32'd0);
  endtask

  task automatic run_reject(input logic [COL_W-1:0] s);
    start = 1'b1; start_col = s; len_code = 2'b00; order_ilv = 1'($urandom);
    @(negedge clk);
    start = 1'b0;
    chk("R8 err pulse", 32'(err), 32'd1);
    chk("R8 no beat", 32'(col_valid), 32'd0);
    chk("R8 busy low", 32'(busy), 32'd0);
    @(negedge clk);
    chk("R8 err clears", 32'(err), 32'd0);
    chk("R8 still no beat", 32'(col_valid), 32'd0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1 col_valid in reset", 32'(col_valid), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 col_valid", 32'(col_valid), 32'd0);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 last", 32'(last), 32'd0);
    chk("R1 err", 32'(err), 32'd0);

    // Exhaustive sweep with nonzero upper bits
    for (int c = 1; c < 4; c++)
      for (int t = 0; t < 2; t++)
        for (int o = 0; o < 8; o++)
          run_burst(COL_W'(10'h2A8 | o), 2'(c), 1'(t), 1'b0);

    // Corner: all ones, sequential, must not carry upward (R7)
    run_burst('1, 2'b11, 1'b0, 1'b0);
    run_burst('1, 2'b01, 1'b0, 1'b1);
    run_reject(10'h155);
    run_burst(10'h3F5, 2'b11, 1'b1, 1'b1);

    // Random mix, start held high with garbage during bursts (R9)
    for (int i = 0; i < 200; i++) begin
      logic [1:0] code;
      code = 2'($urandom);
      if (code == 2'b00) run_reject(COL_W'($urandom));
      else run_burst(COL_W'($urandom), code, 1'($urandom), 1'b1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule